// File: doc/BRIEF.md
# Processor exception control unit

This unit holds the privileged control state that a simple 32-bit processor uses to take exceptions and interrupts. It owns three 32-bit registers outside the general register file: a status word (interrupt masks plus a two-level stack of enable and mode bits), a cause word (the type code of the last event and the pending interrupt lines), and an exception-address word (where the interrupted instruction sits).

When the pipeline reports an internal fault, or when an unmasked pending interrupt meets an enabled processor, the unit saves the faulting address, records the type code, and pushes the enable stack. It then raises a one-cycle redirect with a handler address. The handler address is looked up in a hardware vector table indexed by the type code. A return strobe pops the enable stack and so restores the enable state that held before the event. Software reaches the registers only through a move-to/move-from port that is addressed by register index.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset `redirect_o` is 0 and the registers at indices 12 (status), 13 (cause) and 14 (exception address) all read 0.
- R2: An internal exception (`exc_req_i` high at a clock edge) makes `redirect_o` high for exactly the next cycle. During that cycle `target_o` equals VEC_BASE + code × VEC_STRIDE (defaults 0x8000_0000 and 0x80), for every 4-bit code.
- R3: Taking any event loads the exception-address register with `exc_pc_i` and loads cause bits [5:2] with the event's type code (0 for an interrupt, 10 for undefined instruction, 12 for overflow).
- R4: Taking any event pushes the status stack: bits [3:2] receive the old bits [1:0], and bits [1:0] (bit 0 is the current enable, bit 1 the current mode) become 0.
- R5: A return strobe with no event taken in the same cycle pops the stack: bits [1:0] receive the old bits [3:2], and bits [3:2] become 0.
- R6: Cause bits [15:10] show the interrupt lines `irq_i[5:0]` as sampled at the previous clock edge.
- R7: An interrupt is taken at a clock edge only when some line is both pending (cause [15:10]) and unmasked (status [15:10]), and status bit 0 is 1. Its handler address is VEC_BASE.
- R8: When an internal exception and a qualifying interrupt arrive at the same edge, the internal exception's code is recorded and its handler address is used.
- R9: A write to index 12 changes only status bits [15:10] and [3:0]; all other status bits read 0. A write to index 14 loads all 32 bits. A write to index 13 has no effect. Any other index reads 0.
- R10: A taken event overrides a register write and a return strobe in the same cycle: the exception address comes from `exc_pc_i`, and the status stack is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 1 | Internal exception request |
| exc_code_i | input | 4 | Type code of the internal exception |
| exc_pc_i | input | 32 | Address of the current/faulting instruction |
| irq_i | input | 6 | External interrupt request lines |
| eret_i | input | 1 | Return-from-exception strobe |
| csr_we_i | input | 1 | Control-register write enable |
| csr_idx_i | input | 5 | Control-register index |
| csr_wdata_i | input | 32 | Control-register write data |
| csr_rdata_o | output | 32 | Control-register read data (combinational) |
| redirect_o | output | 1 | Fetch redirect valid, one cycle |
| target_o | output | 32 | Handler address for the redirect |

## Verification
An internal exception shows its results at the first clock edge after the request: redirect, target, exception address, cause code and pushed stack. The redirect drops again at the second edge. An interrupt line shows up as pending one edge after it is raised, and it is taken at the edge after that, so its redirect appears two edges after the stimulus. Register reads are combinational. The bench changes inputs on the falling edge and reads the outputs at the following falling edge, or a nanosecond after an index change, so every check lands in the cycle where the result is due. It sweeps all sixteen codes, every interrupt line under all four mask/enable combinations, and the same-cycle collisions.

// File: rtl/exc_pkg.sv
// Package: shared constants for the exception control unit.
// Assumes a 32-bit datapath and 5-bit control-register indices.
package exc_pkg;
    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    localparam logic [4:0] IDX_STATUS = 5'd12;
    localparam logic [4:0] IDX_CAUSE  = 5'd13;
    localparam logic [4:0] IDX_EPC    = 5'd14;

    localparam int CODE_LSB = 2;   // type code field position in cause
    localparam int PEND_LSB = 10;  // pending lines position in cause
    localparam int MASK_LSB = 10;  // mask bits position in status
    localparam int STK_W    = 4;   // two levels of {mode, enable}

    localparam logic [3:0] CODE_IRQ   = 4'd0;
    localparam logic [3:0] CODE_UNDEF = 4'd10;
    localparam logic [3:0] CODE_OVF   = 4'd12;
endpackage

// File: rtl/exc_status_reg.sv
// Status register: interrupt masks and a two-level {mode, enable} stack.
// Assumes take_i, eret_i and wr_i may coincide; take beats eret beats write.
module exc_status_reg
    import exc_pkg::*;
#(
    parameter int N_IRQ = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             eret_i,
    input  logic             wr_i,
    input  logic [STK_W-1:0] wr_stk_i,
    input  logic [N_IRQ-1:0] wr_mask_i,
    output word_t            status_o,
    output logic             ie_o,
    output logic [N_IRQ-1:0] mask_o
);
    logic [STK_W-1:0] stk_q;
    logic [N_IRQ-1:0] mask_q;

    // Stack push on an event, pop on return, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q  <= '0;
            mask_q <= '0;
        end else if (take_i) begin
            stk_q <= {stk_q[1:0], 2'b00};
        end else if (eret_i) begin
            stk_q <= {2'b00, stk_q[3:2]};
        end else if (wr_i) begin
            stk_q  <= wr_stk_i;
            mask_q <= wr_mask_i;
        end
    end

    // Assemble the architectural status word; unused bits read 0.
    always_comb begin
        status_o                     = '0;
        status_o[STK_W-1:0]          = stk_q;
        status_o[MASK_LSB +: N_IRQ]  = mask_q;
    end

    assign ie_o   = stk_q[0];
    assign mask_o = mask_q;
endmodule

// File: rtl/exc_cause_reg.sv
// Cause register: last event type code and sampled interrupt lines.
// Assumes software never writes it; pending lines are resampled each cycle.
module exc_cause_reg
    import exc_pkg::*;
#(
    parameter int N_IRQ  = 6,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    output word_t             cause_o,
    output logic [N_IRQ-1:0]  pend_o
);
    logic [N_IRQ-1:0]  pend_q;
    logic [CODE_W-1:0] code_q;

    // Sample the interrupt lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_i;
    end

    // Record the type code of a taken event.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (take_i) code_q <= code_i;
    end

    // Assemble the architectural cause word.
    always_comb begin
        cause_o                       = '0;
        cause_o[CODE_LSB +: CODE_W]   = code_q;
        cause_o[PEND_LSB +: N_IRQ]    = pend_q;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/exc_vector_table.sv
// Handler vector table: one entry per type code, evenly spaced from a base.
// Assumes base and stride fit the 32-bit address space for every code.
module exc_vector_table
    import exc_pkg::*;
#(
    parameter int    CODE_W     = 4,
    parameter word_t VEC_BASE   = 32'h8000_0000,
    parameter word_t VEC_STRIDE = 32'h0000_0080
) (
    input  logic [CODE_W-1:0] code_i,
    output word_t             addr_o
);
    localparam int N_VEC = 1 << CODE_W;

    word_t tbl [N_VEC];

    for (genvar g = 0; g < N_VEC; g++) begin : g_entry
        assign tbl[g] = VEC_BASE + word_t'(g) * VEC_STRIDE;
    end

    assign addr_o = tbl[code_i];
endmodule

// File: rtl/exc_ctrl_unit.sv
// Exception control unit top: arbitrates internal exceptions against
// enabled interrupts, saves the faulting address, and issues a registered
// one-cycle redirect to the vectored handler. Assumes the pipeline holds
// exc_pc_i at the current instruction address every cycle.
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int    N_IRQ      = 6,
    parameter int    CODE_W     = 4,
    parameter word_t VEC_BASE   = 32'h8000_0000,
    parameter word_t VEC_STRIDE = 32'h0000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [31:0]       exc_pc_i,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              eret_i,
    input  logic              csr_we_i,
    input  logic [4:0]        csr_idx_i,
    input  logic [31:0]       csr_wdata_i,
    output logic [31:0]       csr_rdata_o,
    output logic              redirect_o,
    output logic [31:0]       target_o
);
    word_t             status_w, cause_w, vec_addr;
    logic              ie;
    logic [N_IRQ-1:0]  mask, pend;
    logic              irq_hit, take;
    logic [CODE_W-1:0] sel_code;
    word_t             epc_q, target_q;
    logic              redirect_q;

    // Event arbitration: internal exceptions win over interrupts.
    always_comb begin
        irq_hit  = (|(pend & mask)) && ie;
        take     = exc_req_i || irq_hit;
        sel_code = exc_req_i ? exc_code_i : CODE_W'(CODE_IRQ);
    end

    exc_status_reg #(.N_IRQ(N_IRQ)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .eret_i    (eret_i),
        .wr_i      (csr_we_i && csr_idx_i == IDX_STATUS),
        .wr_stk_i  (csr_wdata_i[STK_W-1:0]),
        .wr_mask_i (csr_wdata_i[MASK_LSB +: N_IRQ]),
        .status_o  (status_w),
        .ie_o      (ie),
        .mask_o    (mask)
    );

    exc_cause_reg #(.N_IRQ(N_IRQ), .CODE_W(CODE_W)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .take_i  (take),
        .code_i  (sel_code),
        .cause_o (cause_w),
        .pend_o  (pend)
    );

    exc_vector_table #(
        .CODE_W(CODE_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .code_i (sel_code),
        .addr_o (vec_addr)
    );

    // Exception address: captured on an event, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                epc_q <= '0;
        else if (take)                             epc_q <= exc_pc_i;
        else if (csr_we_i && csr_idx_i == IDX_EPC) epc_q <= csr_wdata_i;
    end

    // Registered redirect pulse and handler address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_q <= 1'b0;
            target_q   <= '0;
        end else begin
            redirect_q <= take;
            if (take) target_q <= vec_addr;
        end
    end

    // Move-from read port.
    always_comb begin
        unique case (csr_idx_i)
            IDX_STATUS: csr_rdata_o = status_w;
            IDX_CAUSE:  csr_rdata_o = cause_w;
            IDX_EPC:    csr_rdata_o = epc_q;
            default:    csr_rdata_o = '0;
        endcase
    end

    assign redirect_o = redirect_q;
    assign target_o   = target_q;
endmodule

// File: rtl/exc_ctrl_unit_chk.sv
// Checker: temporal properties of the exception control unit, bound to
// the top module. Assumes the default 4-bit type code width.
module exc_ctrl_unit_chk #(
    parameter int          CODE_W     = 4,
    parameter logic [31:0] VEC_BASE   = 32'h8000_0000,
    parameter logic [31:0] VEC_STRIDE = 32'h0000_0080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic [31:0]       exc_pc_i,
    input logic              eret_i,
    input logic              redirect_o,
    input logic [31:0]       target_o,
    input logic              take,
    input logic [3:0]        stk,
    input logic [CODE_W-1:0] cause_code,
    input logic [31:0]       epc
);
    assert_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_o);

    assert_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> target_o == VEC_BASE + 32'(cause_code) * VEC_STRIDE);

    assert_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> epc == $past(exc_pc_i));

    assert_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> stk == {$past(stk[1:0]), 2'b00});

    assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !take) |=> stk == {2'b00, $past(stk[3:2])});

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !exc_req_i) |-> stk[0]);

    assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |=> cause_code == $past(exc_code_i));
endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk #(
    .CODE_W(CODE_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_req_i  (exc_req_i),
    .exc_code_i (exc_code_i),
    .exc_pc_i   (exc_pc_i),
    .eret_i     (eret_i),
    .redirect_o (redirect_o),
    .target_o   (target_o),
    .take       (take),
    .stk        (status_w[3:0]),
    .cause_code (cause_w[2 +: CODE_W]),
    .epc        (epc_q)
);

// File: tb/test_exc_ctrl_unit.sv
module test_exc_ctrl_unit;
    localparam logic [31:0] BASE   = 32'h8000_0000;
    localparam logic [31:0] STRIDE = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req_i = 1'b0;
    logic [3:0]  exc_code_i = '0;
    logic [31:0] exc_pc_i = '0;
    logic [5:0]  irq_i = '0;
    logic        eret_i = 1'b0;
    logic        csr_we_i = 1'b0;
    logic [4:0]  csr_idx_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        redirect_o;
    logic [31:0] target_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    exc_ctrl_unit i_exc_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .exc_code_i(exc_code_i),
        .exc_pc_i(exc_pc_i), .irq_i(irq_i), .eret_i(eret_i), .csr_we_i(csr_we_i),
        .csr_idx_i(csr_idx_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .redirect_o(redirect_o), .target_o(target_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] v);
        csr_idx_i = idx;
        #1;
        v = csr_rdata_o;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] v);
        csr_we_i = 1'b1; csr_idx_i = idx; csr_wdata_i = v;
        tick();
        csr_we_i = 1'b0;
    endtask

    task automatic ret();
        eret_i = 1'b1;
        tick();
        eret_i = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 redirect", {31'd0, redirect_o}, 32'd0);
        rd(5'd12, v); chk("R1 status", v, 32'd0);
        rd(5'd13, v); chk("R1 cause", v, 32'd0);
        rd(5'd14, v); chk("R1 epc", v, 32'd0);

        // R9: register access rules
        wr(5'd12, 32'hFFFF_FFFF); rd(5'd12, v); chk("R9 status mask", v, 32'h0000_FC0F);
        wr(5'd12, 32'h0);
        wr(5'd13, 32'hFFFF_FFFF); rd(5'd13, v); chk("R9 cause ignored", v, 32'h0);
        wr(5'd14, 32'h1234_5678); rd(5'd14, v); chk("R9 epc write", v, 32'h1234_5678);
        rd(5'd7, v); chk("R9 other idx", v, 32'h0);

        // R2..R5: sweep of every type code
        for (int c = 0; c < 16; c++) begin
            logic [31:0] pc;
            pc = 32'h0040_0000 + 32'(c) * 4;
            wr(5'd12, 32'(c));
            exc_req_i = 1'b1; exc_code_i = 4'(c); exc_pc_i = pc;
            tick();
            exc_req_i = 1'b0;
            chk("R2 redirect high", {31'd0, redirect_o}, 32'd1);
            chk("R2 target", target_o, BASE + 32'(c) * STRIDE);
            rd(5'd12, v); chk("R4 push", v, {28'd0, 2'(c), 2'b00});
            rd(5'd13, v); chk("R3 cause code", v, 32'(c) << 2);
            rd(5'd14, v); chk("R3 epc", v, pc);
            tick();
            chk("R2 one-cycle pulse", {31'd0, redirect_o}, 32'd0);
            ret();
            rd(5'd12, v); chk("R5 pop", v, {30'd0, 2'(c)});
        end

        // R6/R7: each line under each mask/enable combination
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] st, pc;
                logic        hit;
                hit = (m == 3);
                st  = ((m & 1) != 0 ? (32'd1 << (10 + i)) : 32'd0) | ((m & 2) != 0 ? 32'd1 : 32'd0);
                pc  = 32'h0000_1000 + 32'(i * 16 + m);
                wr(5'd12, st);
                irq_i = 6'(1 << i); exc_pc_i = pc;
                tick();
                chk("R7 no take before pending", {31'd0, redirect_o}, 32'd0);
                rd(5'd13, v); chk("R6 pending", v & 32'h0000_FC00, 32'd1 << (10 + i));
                tick();
                chk("R7 take gate", {31'd0, redirect_o}, {31'd0, hit});
                irq_i = '0;
                if (hit) begin
                    chk("R7 target", target_o, BASE);
                    rd(5'd13, v); chk("R3 irq code", v & 32'h3C, 32'd0);
                    rd(5'd14, v); chk("R3 irq epc", v, pc);
                    rd(5'd12, v); chk("R4 irq push", v & 32'hF, 32'h4);
                end
                tick();
                rd(5'd13, v); chk("R6 pending cleared", v & 32'h0000_FC00, 32'd0);
                if (hit) begin
                    ret();
                    rd(5'd12, v); chk("R5 irq pop", v, st);
                end
            end
        end

        // R7: unmasked line not pending, pending lines masked
        wr(5'd12, 32'h0000_8001);
        irq_i = 6'b011111;
        tick(); tick();
        chk("R7 masked lines", {31'd0, redirect_o}, 32'd0);
        irq_i = '0; tick();

        // R8: internal exception beats a qualifying interrupt
        wr(5'd12, 32'h0000_FC01);
        irq_i = 6'b000001;
        tick();
        exc_req_i = 1'b1; exc_code_i = 4'd12; exc_pc_i = 32'h0000_ABC0;
        tick();
        exc_req_i = 1'b0; irq_i = '0;
        chk("R8 redirect", {31'd0, redirect_o}, 32'd1);
        chk("R8 target", target_o, BASE + 32'd12 * STRIDE);
        rd(5'd13, v); chk("R8 cause code", v & 32'h3C, 32'd12 << 2);
        rd(5'd14, v); chk("R8 epc", v, 32'h0000_ABC0);
        tick();
        ret();

        // R10: event beats a same-cycle write and return
        wr(5'd12, 32'h3);
        csr_we_i = 1'b1; csr_idx_i = 5'd14; csr_wdata_i = 32'hDEAD_BEEF;
        eret_i = 1'b1; exc_req_i = 1'b1; exc_code_i = 4'd10; exc_pc_i = 32'h0000_2000;
        tick();
        csr_we_i = 1'b0; eret_i = 1'b0; exc_req_i = 1'b0;
        rd(5'd14, v); chk("R10 epc over write", v, 32'h0000_2000);
        rd(5'd12, v); chk("R10 push over return", v, 32'hC);
        rd(5'd13, v); chk("R10 cause code", v & 32'h3C, 32'd10 << 2);
        csr_we_i = 1'b1; csr_idx_i = 5'd12; csr_wdata_i = 32'h0000_FC0F;
        exc_req_i = 1'b1; exc_code_i = 4'd12;
        tick();
        csr_we_i = 1'b0; exc_req_i = 1'b0;
        rd(5'd12, v); chk("R10 push over status write", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule